// File: doc/BRIEF.md
# Registered 32-bit Arithmetic-Logic Unit with Zero Flag

This block computes one of six operations on two operand words, selected by a 4-bit operation code: three bitwise functions (AND, OR, NOR), wrap-around addition and subtraction, and a signed less-than comparison that yields 1 or 0. Beside the result word it raises a flag whenever that result is all zeros.

The zero flag lets a branch unit test two registers for equality. It issues the subtract code and reads the flag. Any code outside the six defined values gives a zero result, so the flag is then set.

Both outputs are registered. A result appears one clock after its operands and code are presented. A synchronous, active-high reset clears the result and sets the flag.

Top module: `alu32_core`

## Requirements
- R1: Operation code 4'b0000 produces the bitwise AND of operands A and B.
- R2: Operation code 4'b0001 produces the bitwise OR of A and B.
- R3: Operation code 4'b0010 produces A + B modulo 2^32; a carry out of bit 31 is dropped silently.
- R4: Operation code 4'b0110 produces A - B modulo 2^32; a borrow is dropped silently.
- R5: Operation code 4'b0111 produces 32'd1 when A is less than B as signed two's-complement values, else 32'd0. This holds also when A - B overflows, for example A = 32'h8000_0000 and B = 32'h0000_0001 gives 1.
- R6: Operation code 4'b1100 produces the bitwise NOR of A and B.
- R7: Every other operation code produces a result of 32'd0, whatever the operands.
- R8: The zero output is 1 exactly when the 32-bit result output is all zeros.
- R9: Results are registered. The outputs in the cycle after a rising edge reflect the operands and code sampled at that edge.
- R10: While reset is high at a rising edge, the result becomes 0 and the zero output becomes 1 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| result_o | output | 32 | Registered result |
| zero_o | output | 1 | Registered flag, 1 when result_o is zero |

## Verification
The bench drives all sixteen codes against a grid of corner operands, then against a long pseudo-random stream. The corner operands are zero, one, all ones, and the most positive and most negative values. The signed comparison is aimed at operand pairs whose difference overflows. A design that read the sign from a 32-bit difference would invert the answer there, for example reporting the most negative value as not below one. A design that let the carry escape or decoded a spare code as a live operation would show a nonzero word where zero is expected. Equal operands under subtract confirm that the flag goes high exactly when the word is zero.

// File: rtl/alu32_pkg.sv
package alu32_pkg;

  typedef enum logic [3:0] {
    OPC_AND  = 4'b0000,
    OPC_OR   = 4'b0001,
    OPC_ADD  = 4'b0010,
    OPC_SUB  = 4'b0110,
    OPC_SLT  = 4'b0111,
    OPC_NOR  = 4'b1100
  } alu_opc_e;

  localparam int unsigned OPC_W = 4;

endpackage

// File: rtl/alu32_bitwise.sv
module alu32_bitwise #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] lhs,
  input  logic [WIDTH-1:0] rhs,
  output logic [WIDTH-1:0] and_w,
  output logic [WIDTH-1:0] or_w,
  output logic [WIDTH-1:0] nor_w
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    assign and_w[g] = lhs[g] & rhs[g];
    assign or_w[g]  = lhs[g] | rhs[g];
    assign nor_w[g] = ~(lhs[g] | rhs[g]);
  end
endmodule

// File: rtl/alu32_arith.sv
module alu32_arith #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] lhs,
  input  logic [WIDTH-1:0] rhs,
  output logic [WIDTH-1:0] sum_w,
  output logic [WIDTH-1:0] diff_w,
  output logic             lt_signed
);
  localparam int unsigned EXT_W = WIDTH + 1;

  logic [EXT_W-1:0] lhs_ext;
  logic [EXT_W-1:0] rhs_ext;
  logic [EXT_W-1:0] diff_ext;

  // Sign-extended difference cannot overflow, so its top bit is the true sign.
  assign lhs_ext   = {lhs[WIDTH-1], lhs};
  assign rhs_ext   = {rhs[WIDTH-1], rhs};
  assign diff_ext  = lhs_ext - rhs_ext;
  assign sum_w     = lhs + rhs;
  assign diff_w    = diff_ext[WIDTH-1:0];
  assign lt_signed = diff_ext[WIDTH];
endmodule

// File: rtl/alu32_zero_detect.sv
module alu32_zero_detect #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned CHUNK = 8
) (
  input  logic [WIDTH-1:0] value,
  output logic             is_zero
);
  localparam int unsigned NCHUNK = (WIDTH + CHUNK - 1) / CHUNK;
  localparam int unsigned PAD_W  = NCHUNK * CHUNK;

  logic [PAD_W-1:0]  padded;
  logic [NCHUNK-1:0] chunk_any;

  assign padded = PAD_W'(value);

  for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
    assign chunk_any[c] = |padded[c*CHUNK +: CHUNK];
  end

  assign is_zero = ~|chunk_any;
endmodule

// File: rtl/alu32_core.sv
module alu32_core
  import alu32_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o
);
  logic [WIDTH-1:0] and_w, or_w, nor_w, sum_w, diff_w;
  logic             lt_w;
  logic [WIDTH-1:0] sel_w;
  logic             sel_zero;

  alu32_bitwise #(.WIDTH(WIDTH)) u_bitwise (
    .lhs(a_i), .rhs(b_i), .and_w(and_w), .or_w(or_w), .nor_w(nor_w)
  );

  alu32_arith #(.WIDTH(WIDTH)) u_arith (
    .lhs(a_i), .rhs(b_i), .sum_w(sum_w), .diff_w(diff_w), .lt_signed(lt_w)
  );

  always_comb begin
    case (op_i)
      OPC_AND: sel_w = and_w;
      OPC_OR:  sel_w = or_w;
      OPC_ADD: sel_w = sum_w;
      OPC_SUB: sel_w = diff_w;
      OPC_SLT: sel_w = WIDTH'(lt_w);
      OPC_NOR: sel_w = nor_w;
      default: sel_w = '0;
    endcase
  end

  alu32_zero_detect #(.WIDTH(WIDTH), .CHUNK(8)) u_zero (
    .value(sel_w), .is_zero(sel_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      zero_o   <= 1'b1;
    end else begin
      result_o <= sel_w;
      zero_o   <= sel_zero;
    end
  end

  assert_and_R1: assert property (@(posedge clk) disable iff (rst)
    (op_i == OPC_AND) |=> (result_o == ($past(a_i) & $past(b_i))));

  assert_add_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (op_i == OPC_ADD) |=> (result_o == WIDTH'($past(a_i) + $past(b_i))));

  assert_sub_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (op_i == OPC_SUB) |=> (result_o == WIDTH'($past(a_i) - $past(b_i))));

  assert_slt_signed_R5: assert property (@(posedge clk) disable iff (rst)
    (op_i == OPC_SLT) |=>
      (result_o == WIDTH'($signed($past(a_i)) < $signed($past(b_i)))));

  assert_spare_code_R7: assert property (@(posedge clk) disable iff (rst)
    !(op_i inside {OPC_AND, OPC_OR, OPC_ADD, OPC_SUB, OPC_SLT, OPC_NOR})
      |=> (result_o == '0));

  assert_zero_flag_R8: assert property (@(posedge clk) disable iff (rst)
    zero_o == (result_o == '0));

  assert_reset_state_R10: assert property (@(posedge clk)
    rst |=> (result_o == '0 && zero_o));

endmodule

// File: tb/alu32_core_test.sv
module alu32_core_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [3:0]   op  = 4'd0;
  logic [W-1:0] a   = '0;
  logic [W-1:0] b   = '0;
  logic [W-1:0] result;
  logic         zero;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  alu32_core #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .op_i(op), .a_i(a), .b_i(b),
    .result_o(result), .zero_o(zero)
  );

  function automatic logic [W-1:0] model(input logic [3:0] c,
                                         input logic [W-1:0] x,
                                         input logic [W-1:0] y);
    logic [63:0] wide;
    case (c)
      4'b0000: return x & y;
      4'b0001: return x | y;
      4'b0010: begin wide = {32'd0, x} + {32'd0, y}; return wide[W-1:0]; end
      4'b0110: begin wide = {32'd0, x} + {32'd0, ~y} + 64'd1; return wide[W-1:0]; end
      4'b0111: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      4'b1100: return ~(x | y);
      default: return '0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] c);
    case (c)
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b0010: return "R3";
      4'b0110: return "R4";
      4'b0111: return "R5";
      4'b1100: return "R6";
      default: return "R7";
    endcase
  endfunction

  // Drive at falling edge, capture at rising edge, sample at next falling edge (R9).
  task automatic run_op(input logic [3:0] c, input logic [W-1:0] x,
                        input logic [W-1:0] y);
    logic [W-1:0] exp_r;
    op = c; a = x; b = y;
    exp_r = model(c, x, y);
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (result !== exp_r) begin
      fails++;
      $display("FAIL %s R9 op=%b a=%h b=%h result actual=%h expected=%h",
               req_of(c), c, x, y, result, exp_r);
    end
    checks++;
    if (zero !== (exp_r == '0)) begin
      fails++;
      $display("FAIL R8 op=%b a=%h b=%h zero actual=%b expected=%b",
               c, x, y, zero, (exp_r == '0));
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired, actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] corners [6];
    logic [W-1:0] ra, rb;
    corners[0] = 32'h0000_0000; corners[1] = 32'h0000_0001;
    corners[2] = 32'hFFFF_FFFF; corners[3] = 32'h7FFF_FFFF;
    corners[4] = 32'h8000_0000; corners[5] = 32'h1234_5678;

    // R10: reset state, even with live inputs driven during reset
    op = 4'b0001; a = 32'hFFFF_FFFF; b = 32'h1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (result !== '0 || zero !== 1'b1) begin
      fails++;
      $display("FAIL R10 reset actual=%h/%b expected=00000000/1", result, zero);
    end
    rst = 1'b0;

    // R5 overflow corners
    run_op(4'b0111, 32'h8000_0000, 32'h0000_0001);
    run_op(4'b0111, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    run_op(4'b0111, 32'hFFFF_FFFF, 32'h0000_0000);
    run_op(4'b0111, 32'h0000_0005, 32'h0000_0005);
    // R3 and R4 wrap
    run_op(4'b0010, 32'hFFFF_FFFF, 32'h0000_0001);
    run_op(4'b0110, 32'h0000_0000, 32'h0000_0001);
    // R8 equality via subtract
    run_op(4'b0110, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    // R6 NOR producing zero
    run_op(4'b1100, 32'hFFFF_0000, 32'h0000_FFFF);

    // Sweep every code across the corner grid (R1..R7)
    for (int c = 0; c < 16; c++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          run_op(4'(c), corners[i], corners[j]);

    // Pseudo-random stream over all codes
    for (int k = 0; k < 4000; k++) begin
      ra = $urandom; rb = $urandom;
      if (k % 7 == 0) rb = ra;
      run_op(4'(k % 16), ra, rb);
    end

    // R10: reset mid-stream clears outputs
    op = 4'b0001; a = 32'h5; b = 32'h0;
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    checks++;
    if (result !== '0 || zero !== 1'b1) begin
      fails++;
      $display("FAIL R10 mid reset actual=%h/%b expected=00000000/1", result, zero);
    end
    rst = 1'b0;
    run_op(4'b0001, 32'h5, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule